// File: doc/BRIEF.md
# Peak-Ratio-Steered LMS Coefficient Updater

This block adapts a small bank of complex predistorter coefficients while transmission continues. On each qualified cycle it receives one time-aligned complex error sample, which is the difference between the reference and the observed amplifier output. It also receives one complex basis sample per coefficient. For each coefficient it adds the error times the conjugate of that coefficient's basis sample. Before the addition, the product is scaled down by a power-of-two step. All arithmetic is fixed-point, and every coefficient register clamps at its range limits instead of wrapping.

The step is not fixed. A meter watches the power of the reference over consecutive windows. It compares the peak power, multiplied by the window length, against the summed power multiplied by two constant thresholds. No divider is used. Signals that rarely reach high peaks select a small step. Signals with a strong peak-to-average ratio select a large step.

Updated coefficients are sent to a downstream coefficient bank together with a one-cycle strobe. In per-sample mode they go out after every update. In frame mode they go out only when a frame boundary arrives. A freeze input stops adaptation while the feedback path is not trustworthy.

Top module: `lms_coef_updater`

The control is a two-state machine:
- `ST_IDLE`: the published copy equals the working coefficients.
- `ST_COLLECT`: the working coefficients hold updates that have not been published yet.

Transitions:
- `T_DEFER`: `ST_IDLE` to `ST_COLLECT`. An update occurs without a publish.
- `T_FLUSH`: `ST_COLLECT` to `ST_IDLE`. A publish occurs.
- `T_STAY`: any state to itself. Covers a publish taken from `ST_IDLE`, and all other cycles.

## Requirements
- R1: During and right after reset, the published coefficient 0 is real unity (2^(CW-2), imaginary 0) and all other coefficients are zero. `coef_valid` is low, and the step level is the slowest.
- R2: When `in_valid` is high and `freeze` is low, each coefficient k gets delta added. The real part of delta is (e_i*phi_i + e_q*phi_q) >>> S. The imaginary part is (e_q*phi_i - e_i*phi_q) >>> S. Here >>> is an arithmetic (flooring) shift, and S is SH_SLOW, SH_MID or SH_FAST for the current step level.
- R3: Each coefficient part saturates at 2^(CW-1)-1 and -2^(CW-1) and never wraps.
- R4: The meter closes a window on every WIN-th sample with `in_valid` high. It computes P = peak |x|^2 times WIN and S = sum |x|^2 over the window. P >= TH_HI*S selects fast. Otherwise P >= TH_LO*S selects mid. Otherwise the level is slow. A window with zero peak always selects slow. The new level applies from the next update onward.
- R5: With `frame_mode` low, every update is published. `coef_valid` pulses high in the next cycle, with the updated values on `coef_i`/`coef_q`.
- R6: With `frame_mode` high, publishing happens only in a cycle with `frame_end` high when an update is pending or occurs in that same cycle. With no `frame_end`, `coef_valid` stays low.
- R7: With `freeze` high, no coefficient changes. In per-sample mode nothing is published.
- R8: The meter counts every sample with `in_valid` high, whether or not `freeze` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input samples are valid this cycle |
| frame_mode | input | 1 | 1: publish at frame boundaries; 0: publish every update |
| frame_end | input | 1 | Frame boundary strobe |
| freeze | input | 1 | Hold coefficients (feedback invalid) |
| ref_i | input | DW | Reference sample, in-phase |
| ref_q | input | DW | Reference sample, quadrature |
| err_i | input | DW | Error sample, in-phase |
| err_q | input | DW | Error sample, quadrature |
| phi_i | input | K*DW | Basis samples, in-phase, coefficient k at bits [k*DW +: DW] |
| phi_q | input | K*DW | Basis samples, quadrature, same packing |
| coef_valid | output | 1 | Published coefficients are new this cycle |
| coef_i | output | K*CW | Published coefficients, real part, packed like phi |
| coef_q | output | K*CW | Published coefficients, imaginary part |

## Verification
The assertions assume that the data inputs are always at known values and that `frame_end` carries meaning only when the mode says so. They also assume the threshold parameters stay small enough that TH*sum fits the three guard bits of the comparator.

The stimulus keeps every sample inside the signed DW range. Reference patterns cycle through four window shapes, so that every step level, including the zero-energy case, is reached. The error and basis amplitudes are bounded during normal sweeps, and full-scale values appear only in the saturation phase. This keeps any clamp there deliberate and not incidental.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic [1:0] {
        LVL_SLOW = 2'd0,
        LVL_MID  = 2'd1,
        LVL_FAST = 2'd2
    } step_lvl_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } pub_state_e;
endpackage

// File: rtl/lms_papr_meter.sv
module lms_papr_meter
    import lms_pkg::*;
#(
    parameter int DW     = 16,
    parameter int WIN    = 256,
    parameter int TH_LO  = 2,
    parameter int TH_HI  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] x_q,
    output step_lvl_e            lvl
);
    localparam int LW   = $clog2(WIN);
    localparam int PW   = 2 * DW;
    localparam int SUMW = PW + LW;
    localparam int CMPW = SUMW + 3;

    logic [LW-1:0]          cnt;
    logic [PW-1:0]          peak;
    logic [SUMW-1:0]        sum;
    logic signed [PW-1:0]   sq_i, sq_q;
    logic [PW-1:0]          pw;
    logic [PW-1:0]          pk_fin;
    logic [SUMW-1:0]        s_fin;
    logic [CMPW-1:0]        lhs, rhs_hi, rhs_lo;
    logic                   last;
    step_lvl_e              lvl_new;

    assign sq_i   = x_i * x_i;
    assign sq_q   = x_q * x_q;
    assign pw     = $unsigned(sq_i) + $unsigned(sq_q);
    assign pk_fin = (pw > peak) ? pw : peak;
    assign s_fin  = sum + SUMW'(pw);
    assign last   = (cnt == LW'(WIN - 1));
    assign lhs    = CMPW'(pk_fin) << LW;
    assign rhs_hi = CMPW'(s_fin) * CMPW'(TH_HI);
    assign rhs_lo = CMPW'(s_fin) * CMPW'(TH_LO);

    always_comb begin
        lvl_new = LVL_SLOW;
        if (pk_fin != '0) begin
            if (lhs >= rhs_hi)      lvl_new = LVL_FAST;
            else if (lhs >= rhs_lo) lvl_new = LVL_MID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            peak <= '0;
            sum  <= '0;
            lvl  <= LVL_SLOW;
        end else if (smp_valid) begin
            cnt <= cnt + 1'b1;
            if (last) begin
                peak <= '0;
                sum  <= '0;
                lvl  <= lvl_new;
            end else begin
                peak <= pk_fin;
                sum  <= s_fin;
            end
        end
    end

    // R4: the level only moves when a window closes
    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && last) |=> $stable(lvl));
    // R4: only the three defined levels ever appear
    assert_level_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != 2'b11);
endmodule

// File: rtl/lms_coef_cell.sv
module lms_coef_cell
    import lms_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CW      = 18,
    parameter int SH_SLOW = 17,
    parameter int SH_MID  = 15,
    parameter int SH_FAST = 13,
    parameter logic signed [CW-1:0] INIT_I = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  step_lvl_e            lvl,
    input  logic signed [DW-1:0] e_i,
    input  logic signed [DW-1:0] e_q,
    input  logic signed [DW-1:0] p_i,
    input  logic signed [DW-1:0] p_q,
    output logic signed [CW-1:0] c_i,
    output logic signed [CW-1:0] c_q,
    output logic signed [CW-1:0] n_i,
    output logic signed [CW-1:0] n_q
);
    localparam int AW = 2 * DW + 1;
    localparam int SW = ((AW > CW) ? AW : CW) + 1;
    localparam logic signed [CW-1:0] MAXC = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] MINC = {1'b1, {(CW-1){1'b0}}};

    logic signed [2*DW-1:0] m_ii, m_qq, m_qi, m_iq;
    logic signed [AW-1:0]   g_re, g_im, d_re, d_im;
    logic [5:0]             sh;

    assign m_ii = e_i * p_i;
    assign m_qq = e_q * p_q;
    assign m_qi = e_q * p_i;
    assign m_iq = e_i * p_q;
    assign g_re = AW'(m_ii) + AW'(m_qq);
    assign g_im = AW'(m_qi) - AW'(m_iq);

    always_comb begin
        sh = 6'(SH_SLOW);
        case (lvl)
            LVL_MID:  sh = 6'(SH_MID);
            LVL_FAST: sh = 6'(SH_FAST);
            default:  sh = 6'(SH_SLOW);
        endcase
    end

    assign d_re = g_re >>> sh;
    assign d_im = g_im >>> sh;

    function automatic logic signed [CW-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > SW'(MAXC))      return MAXC;
        else if (v < SW'(MINC)) return MINC;
        else                    return CW'(v);
    endfunction

    assign n_i = en ? clamp(SW'(c_i) + SW'(d_re)) : c_i;
    assign n_q = en ? clamp(SW'(c_q) + SW'(d_im)) : c_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_i <= INIT_I;
            c_q <= '0;
        end else begin
            c_i <= n_i;
            c_q <= n_q;
        end
    end

    // R3: a part sitting at a limit stays there when pushed further out
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && c_i == MAXC && !d_re[AW-1]) |=> (c_i == MAXC));
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && c_q == MINC && d_im[AW-1]) |=> (c_q == MINC));
endmodule

// File: rtl/lms_coef_updater.sv
module lms_coef_updater
    import lms_pkg::*;
#(
    parameter int K       = 4,
    parameter int DW      = 16,
    parameter int CW      = 18,
    parameter int WIN     = 256,
    parameter int TH_LO   = 2,
    parameter int TH_HI   = 4,
    parameter int SH_SLOW = 17,
    parameter int SH_MID  = 15,
    parameter int SH_FAST = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              frame_mode,
    input  logic              frame_end,
    input  logic              freeze,
    input  logic [DW-1:0]     ref_i,
    input  logic [DW-1:0]     ref_q,
    input  logic [DW-1:0]     err_i,
    input  logic [DW-1:0]     err_q,
    input  logic [K*DW-1:0]   phi_i,
    input  logic [K*DW-1:0]   phi_q,
    output logic              coef_valid,
    output logic [K*CW-1:0]   coef_i,
    output logic [K*CW-1:0]   coef_q
);
    localparam logic signed [CW-1:0] UNITY = CW'(1) << (CW - 2);

    step_lvl_e   lvl;
    pub_state_e  state_q, state_d;
    logic        upd, pub;
    logic [K*CW-1:0] w_i, w_q, nx_i, nx_q, ini_i;

    assign upd = in_valid && !freeze;

    lms_papr_meter #(.DW(DW), .WIN(WIN), .TH_LO(TH_LO), .TH_HI(TH_HI)) u_meter (
        .clk(clk), .rst_n(rst_n), .smp_valid(in_valid),
        .x_i(ref_i), .x_q(ref_q), .lvl(lvl)
    );

    for (genvar k = 0; k < K; k++) begin : g_cell
        localparam logic signed [CW-1:0] INIT_K = (k == 0) ? UNITY : '0;
        assign ini_i[k*CW +: CW] = INIT_K;
        lms_coef_cell #(
            .DW(DW), .CW(CW), .SH_SLOW(SH_SLOW), .SH_MID(SH_MID),
            .SH_FAST(SH_FAST), .INIT_I(INIT_K)
        ) u_cell (
            .clk(clk), .rst_n(rst_n), .en(upd), .lvl(lvl),
            .e_i(err_i), .e_q(err_q),
            .p_i(phi_i[k*DW +: DW]), .p_q(phi_q[k*DW +: DW]),
            .c_i(w_i[k*CW +: CW]), .c_q(w_q[k*CW +: CW]),
            .n_i(nx_i[k*CW +: CW]), .n_q(nx_q[k*CW +: CW])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and transitions
    always_comb begin
        pub     = (!frame_mode && upd) ||
                  (frame_end && (upd || state_q == ST_COLLECT));
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (upd && !pub) state_d = ST_COLLECT;   // T_DEFER
            end
            ST_COLLECT: begin
                if (pub) state_d = ST_IDLE;              // T_FLUSH
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_valid <= 1'b0;
            coef_i     <= ini_i;
            coef_q     <= '0;
        end else begin
            coef_valid <= pub;
            if (pub) begin
                coef_i <= nx_i;
                coef_q <= nx_q;
            end
        end
    end

    // R7: frozen cycles leave every working coefficient untouched
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && freeze) |=> ($stable(w_i) && $stable(w_q)));
    // R5: each per-sample update is published on the next cycle
    assert_sample_publish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !freeze && !frame_mode) |=> coef_valid);
    // R6: frame mode publishes nothing without a frame boundary
    assert_frame_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mode && !frame_end) |=> !coef_valid);
    // R6: published words only change together with the strobe
    assert_pub_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_valid |-> ($stable(coef_i) && $stable(coef_q)));
endmodule

// File: tb/lms_coef_updater_bench.sv
`timescale 1ns/1ps
module lms_coef_updater_bench;
    localparam int K = 2, DW = 16, CW = 18, WIN = 16;
    localparam int TH_LO = 2, TH_HI = 4;
    localparam int SH_SLOW = 17, SH_MID = 15, SH_FAST = 13;
    localparam longint MAXC = (64'sd1 <<< (CW-1)) - 1;
    localparam longint MINC = -(64'sd1 <<< (CW-1));

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, frame_mode = 0, frame_end = 0, freeze = 0;
    logic [DW-1:0] ref_i = 0, ref_q = 0, err_i = 0, err_q = 0;
    logic [K*DW-1:0] phi_i = 0, phi_q = 0;
    logic coef_valid;
    logic [K*CW-1:0] coef_i, coef_q;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    longint w_i[K], w_q[K], p_i[K], p_q[K];
    bit m_valid, pend;
    int lvl;           // 0 slow 1 mid 2 fast
    int mcnt;
    longint mpeak, msum;
    int vcount, win_idx;

    always #4 clk = ~clk;

    lms_coef_updater #(.K(K), .DW(DW), .CW(CW), .WIN(WIN), .TH_LO(TH_LO),
        .TH_HI(TH_HI), .SH_SLOW(SH_SLOW), .SH_MID(SH_MID), .SH_FAST(SH_FAST))
    u_lms_coef_updater (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_mode(frame_mode),
        .frame_end(frame_end), .freeze(freeze), .ref_i(ref_i), .ref_q(ref_q),
        .err_i(err_i), .err_q(err_q), .phi_i(phi_i), .phi_q(phi_q),
        .coef_valid(coef_valid), .coef_i(coef_i), .coef_q(coef_q));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > MAXC) return MAXC;
        if (v < MINC) return MINC;
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < K; k++) begin
            w_i[k] = (k == 0) ? (64'sd1 <<< (CW-2)) : 0;
            w_q[k] = 0; p_i[k] = w_i[k]; p_q[k] = 0;
        end
        m_valid = 0; pend = 0; lvl = 0; mcnt = 0; mpeak = 0; msum = 0;
    endtask

    task automatic compare(input string vtag, input string ctag);
        chk(vtag, coef_valid, m_valid);
        for (int k = 0; k < K; k++) begin
            chk(ctag, $signed(coef_i[k*CW +: CW]), p_i[k]);
            chk(ctag, $signed(coef_q[k*CW +: CW]), p_q[k]);
        end
    endtask

    // drive one cycle at a negedge, advance the model, compare at next negedge
    task automatic step(input bit v, input bit fm, input bit fe, input bit frz,
                        input longint ri, input longint rq, input longint ei,
                        input longint eq, input longint phr[K], input longint phq[K],
                        input string vtag, input string ctag);
        longint nx_i[K], nx_q[K];
        longint pw, pk, s, sh;
        bit upd, pub;
        in_valid = v; frame_mode = fm; frame_end = fe; freeze = frz;
        ref_i = DW'(ri); ref_q = DW'(rq); err_i = DW'(ei); err_q = DW'(eq);
        for (int k = 0; k < K; k++) begin
            phi_i[k*DW +: DW] = DW'(phr[k]);
            phi_q[k*DW +: DW] = DW'(phq[k]);
        end
        upd = v && !frz;
        sh = (lvl == 2) ? SH_FAST : (lvl == 1) ? SH_MID : SH_SLOW;
        for (int k = 0; k < K; k++) begin
            if (upd) begin
                nx_i[k] = sat(w_i[k] + ((ei*phr[k] + eq*phq[k]) >>> sh));
                nx_q[k] = sat(w_q[k] + ((eq*phr[k] - ei*phq[k]) >>> sh));
            end else begin
                nx_i[k] = w_i[k]; nx_q[k] = w_q[k];
            end
        end
        pub = (!fm && upd) || (fe && (pend || upd));
        m_valid = pub;
        if (pub) for (int k = 0; k < K; k++) begin p_i[k] = nx_i[k]; p_q[k] = nx_q[k]; end
        pend = pub ? 0 : (upd ? 1 : pend);
        for (int k = 0; k < K; k++) begin w_i[k] = nx_i[k]; w_q[k] = nx_q[k]; end
        if (v) begin
            pw = ri*ri + rq*rq;
            pk = (pw > mpeak) ? pw : mpeak;
            s  = msum + pw;
            if (mcnt == WIN-1) begin
                if (pk == 0) lvl = 0;
                else if (pk*WIN >= TH_HI*s) lvl = 2;
                else if (pk*WIN >= TH_LO*s) lvl = 1;
                else lvl = 0;
                mcnt = 0; mpeak = 0; msum = 0;
            end else begin
                mcnt++; mpeak = pk; msum = s;
            end
        end
        @(negedge clk);
        compare(vtag, ctag);
    endtask

    // reference sample for the current window shape (R4 sweep)
    task automatic pick_ref(output longint ri, output longint rq);
        int pos;
        pos = vcount % WIN;
        case (win_idx % 4)
            0: begin ri = 1000; rq = -700; end
            1: begin ri = (pos < 8) ? 1200 : 0; rq = 0; end
            2: begin ri = (pos == 3) ? 9000 : 100; rq = (pos == 3) ? -5000 : 50; end
            default: begin ri = 0; rq = 0; end
        endcase
    endtask

    task automatic count_valid(input bit v);
        if (v) begin
            vcount++;
            if (vcount % WIN == 0) win_idx++;
        end
    endtask

    task automatic phase(input int n, input int mode, input string vtag, input string ctag);
        longint phr[K], phq[K];
        longint ri, rq, ei, eq, amp;
        bit v, fm, fe, frz;
        for (int c = 0; c < n; c++) begin
            v   = ($urandom % 10) < 8;
            fm  = (mode == 2) || (mode == 4 && ($urandom % 2) == 1);
            fe  = (mode == 2 || mode == 4) ? ((c % 7) == 6) : (($urandom % 9) == 0);
            frz = (mode == 1) ? (($urandom % 10) < 3) : 0;
            amp = (mode == 3) ? 32767 : 2047;
            pick_ref(ri, rq);
            if (mode == 3) begin
                ei = ((c / 20) % 2 == 0) ? 32767 : -32768;
                eq = -ei;
                if (eq > 32767) eq = 32767;
                for (int k = 0; k < K; k++) begin phr[k] = 32767; phq[k] = -32768; end
            end else begin
                ei = longint'($urandom % (2*amp+1)) - amp;
                eq = longint'($urandom % (2*amp+1)) - amp;
                for (int k = 0; k < K; k++) begin
                    phr[k] = longint'($urandom % (2*amp+1)) - amp;
                    phq[k] = longint'($urandom % (2*amp+1)) - amp;
                end
            end
            step(v, fm, fe, frz, ri, rq, ei, eq, phr, phq, vtag, ctag);
            count_valid(v);
        end
    endtask

    initial begin
        longint zr[K], one[K];
        void'($urandom(7));
        model_reset();
        vcount = 0; win_idx = 0;
        repeat (3) @(negedge clk);
        compare("R1", "R1");                 // held in reset
        rst_n = 1;
        @(negedge clk);
        compare("R1", "R1");                 // first cycle after release

        // directed R4: spike window, then one update shows the fast step
        for (int k = 0; k < K; k++) begin zr[k] = 0; one[k] = 1024; end
        for (int c = 0; c < WIN; c++)
            step(1, 0, 0, 1, (c == 0) ? 8000 : 10, 0, 0, 0, zr, zr, "R8", "R8");
        step(1, 0, 0, 0, 0, 0, 1024, 0, one, zr, "R5", "R4");
        vcount = WIN + 1; win_idx = 1;

        phase(512, 0, "R5", "R2/R4");        // per-sample mode, all window shapes
        phase(512, 1, "R7", "R7/R8");        // random freezes
        phase(512, 2, "R6", "R2");           // frame mode
        phase(160, 3, "R5", "R3");           // full-scale, saturating
        phase(512, 4, "R6", "R2");           // mixed mode switching
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule